// File: doc/BRIEF.md
# DDR Rank Refresh and Low-Power Sequencer

This block sits on the controller side of a DDR SDRAM rank. It owns the clock-enable pin and, when it holds the command bus, the command pins. It counts clock cycles against a programmable refresh interval and banks each elapsed interval as one refresh credit. Credits are spent by issuing auto refresh whenever the arbiter grants the bus and every bank is closed. If credits pile up to a fixed ceiling, the block stops waiting for a grant. It closes any open rows with a precharge-all and then refreshes.

The block also moves the rank into and out of self refresh and power-down on request. While it owns the bus it raises a busy flag, and other requesters must stay off the bus while it is high. This covers the refresh recovery time, the precharge wait, both low-power states and the long stable-clock window after self-refresh exit. Self refresh suspends interval counting. Leaving self refresh clears both the interval count and the banked credits.

Top module: `dram_refresh_pm`

## Requirements
- R1: While reset is held, and right after it, CKE is high, chip select is high (deselect), and busy and urgent are low.
- R2: Each `i_refi_cycles` clock cycles outside self refresh add one refresh credit. With a credit available, grant high and all banks idle, the block drives auto refresh in the following cycle: cs_n=0, ras_n=0, cas_n=0, we_n=1 with CKE high. With grant held, refreshes then repeat every `i_refi_cycles` cycles.
- R3: Credits saturate at `CRED_MAX`. At the ceiling, urgent is high and a refresh is issued in the next cycle without any grant.
- R4: If urgent arises while a bank is open, the block first issues precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1). It issues auto refresh `TRP_CYC` cycles later.
- R5: After an auto refresh, busy stays high for exactly `TRFC_CYC` cycles, counting the refresh cycle, and falls in the next cycle.
- R6: Sleep request with grant and idle banks enters self refresh with the refresh encoding while CKE drops low in that same cycle.
- R7: In self refresh, CKE stays low and no command is driven, however many refresh intervals elapse.
- R8: On wake from self refresh, CKE rises with deselect in the next cycle. Busy then stays high, with no command, for `TXSR_CYC` cycles.
- R9: Self-refresh exit clears credit and interval count. With grant held, the first refresh comes `i_refi_cycles`+1 cycles after CKE rises.
- R10: Power-down request with grant drops CKE with deselect, whether or not banks are open. Wake raises CKE and drops busy in the next cycle.
- R11: In power-down, reaching the credit ceiling raises CKE by itself. The urgent precharge and refresh sequence follows.
- R12: Busy is high in every state except idle: precharge wait, refresh recovery, self refresh, exit window and power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| i_refi_cycles | input | REFI_W | Refresh interval in clock cycles (greater than TRFC_CYC+TRP_CYC) |
| i_grant | input | 1 | Arbiter grants the command bus to this block |
| i_banks_idle | input | 1 | All banks of the rank are precharged |
| i_sleep_req | input | 1 | Request self refresh |
| i_pd_req | input | 1 | Request power-down |
| i_wake | input | 1 | Leave self refresh or power-down |
| o_cke | output | 1 | Clock enable to the rank |
| o_cs_n | output | 1 | Chip select, active low |
| o_ras_n | output | 1 | Row strobe, active low |
| o_cas_n | output | 1 | Column strobe, active low |
| o_we_n | output | 1 | Write enable, active low |
| o_a10 | output | 1 | Address bit 10, high selects all banks on precharge |
| o_busy | output | 1 | Block owns the bus; other requesters hold off |
| o_urgent | output | 1 | Credit ceiling reached |

## Verification
Every output is a register fed by decisions made on the edge that samples the inputs, so each command or CKE change is due one cycle after the input that causes it. Refresh timing is counted from the reset release edge: the first credit appears `i_refi_cycles` edges after that, and the refresh one edge later. The urgent refresh falls at three intervals plus one, and the precharge-to-refresh gap is exactly `TRP_CYC`. The bench counts falling clock edges from the reset release or from the wake stimulus. It samples each result at the computed count, and sweeps several interval values so that an off-by-one in the wrap shows as a wrong spacing.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_WAIT,
    ST_RFC,
    ST_SREF,
    ST_XSR,
    ST_PDN
  } rpm_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } rpm_cmd_t;

  localparam rpm_cmd_t CMD_DESEL = 4'b1111;
  localparam rpm_cmd_t CMD_REF   = 4'b0001;
  localparam rpm_cmd_t CMD_PRE   = 4'b0010;

endpackage

// File: rtl/rpm_credit.sv
module rpm_credit #(
  parameter int REFI_W   = 16,
  parameter int CRED_MAX = 8,
  localparam int CRED_W  = $clog2(CRED_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REFI_W-1:0] refi,
  input  logic              freeze,
  input  logic              clear,
  input  logic              consume,
  output logic              pending,
  output logic              urgent
);

  logic [REFI_W-1:0] icnt;
  logic [CRED_W-1:0] credit;
  logic              tick;
  logic              inc;

  assign tick    = !freeze && (icnt == refi - 1'b1);
  assign inc     = tick && ((credit != CRED_W'(CRED_MAX)) || consume);
  assign pending = (credit != '0);
  assign urgent  = (credit == CRED_W'(CRED_MAX));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      icnt   <= '0;
      credit <= '0;
    end else begin
      if (!freeze) icnt <= tick ? '0 : icnt + 1'b1;
      credit <= credit + CRED_W'(inc) - CRED_W'(consume);
    end
  end

  // R3: the credit count never passes its ceiling
  a_r3_credit_cap: assert property (@(posedge clk) disable iff (rst)
    credit <= CRED_W'(CRED_MAX));

  // R7: interval counter holds still while frozen
  a_r7_frozen_interval: assert property (@(posedge clk) disable iff (rst)
    ($past(freeze) && !$past(clear) && !$past(rst)) |-> $stable(icnt));

endmodule

// File: rtl/rpm_wait_timer.sv
module rpm_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/dram_refresh_pm.sv
module dram_refresh_pm #(
  parameter int REFI_W   = 16,
  parameter int CRED_MAX = 8,
  parameter int TRFC_CYC = 10,
  parameter int TRP_CYC  = 3,
  parameter int TXSR_CYC = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REFI_W-1:0] i_refi_cycles,
  input  logic              i_grant,
  input  logic              i_banks_idle,
  input  logic              i_sleep_req,
  input  logic              i_pd_req,
  input  logic              i_wake,
  output logic              o_cke,
  output logic              o_cs_n,
  output logic              o_ras_n,
  output logic              o_cas_n,
  output logic              o_we_n,
  output logic              o_a10,
  output logic              o_busy,
  output logic              o_urgent
);
  import rpm_pkg::*;

  localparam int TMR_MAX = (TXSR_CYC > TRFC_CYC)
                         ? ((TXSR_CYC > TRP_CYC) ? TXSR_CYC : TRP_CYC)
                         : ((TRFC_CYC > TRP_CYC) ? TRFC_CYC : TRP_CYC);
  localparam int TMR_W = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] TRFC_LD = TMR_W'(TRFC_CYC - 1);
  localparam logic [TMR_W-1:0] TRP_LD  = TMR_W'(TRP_CYC - 1);
  localparam logic [TMR_W-1:0] TXSR_LD = TMR_W'(TXSR_CYC - 1);

  rpm_state_e       state, nxt_state;
  rpm_cmd_t         cmd_q, nxt_cmd;
  logic             cke_q, nxt_cke;
  logic             a10_q, nxt_a10;
  logic             busy_q, nxt_busy;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             pending, urgent, consume, sr_exit;

  rpm_credit #(.REFI_W(REFI_W), .CRED_MAX(CRED_MAX)) u_credit (
    .clk     (clk),
    .rst     (rst),
    .refi    (i_refi_cycles),
    .freeze  (state == ST_SREF),
    .clear   (sr_exit),
    .consume (consume),
    .pending (pending),
    .urgent  (urgent)
  );

  rpm_wait_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    nxt_state = state;
    nxt_cmd   = CMD_DESEL;
    nxt_a10   = 1'b0;
    nxt_cke   = cke_q;
    nxt_busy  = busy_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    sr_exit   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (urgent) begin
          nxt_busy = 1'b1;
          tmr_load = 1'b1;
          if (i_banks_idle) begin
            nxt_cmd   = CMD_REF;
            nxt_state = ST_RFC;
            tmr_val   = TRFC_LD;
          end else begin
            nxt_cmd   = CMD_PRE;
            nxt_a10   = 1'b1;
            nxt_state = ST_PRE_WAIT;
            tmr_val   = TRP_LD;
          end
        end else if (i_sleep_req && i_grant && i_banks_idle) begin
          nxt_cmd   = CMD_REF;
          nxt_cke   = 1'b0;
          nxt_busy  = 1'b1;
          nxt_state = ST_SREF;
        end else if (pending && i_grant && i_banks_idle) begin
          nxt_cmd   = CMD_REF;
          nxt_busy  = 1'b1;
          nxt_state = ST_RFC;
          tmr_load  = 1'b1;
          tmr_val   = TRFC_LD;
        end else if (i_pd_req && i_grant) begin
          nxt_cke   = 1'b0;
          nxt_busy  = 1'b1;
          nxt_state = ST_PDN;
        end
      end
      ST_PRE_WAIT: begin
        if (tmr_zero) begin
          nxt_cmd   = CMD_REF;
          nxt_state = ST_RFC;
          tmr_load  = 1'b1;
          tmr_val   = TRFC_LD;
        end
      end
      ST_RFC, ST_XSR: begin
        if (tmr_zero) begin
          nxt_busy  = 1'b0;
          nxt_state = ST_IDLE;
        end
      end
      ST_SREF: begin
        if (i_wake) begin
          nxt_cke   = 1'b1;
          sr_exit   = 1'b1;
          nxt_state = ST_XSR;
          tmr_load  = 1'b1;
          tmr_val   = TXSR_LD;
        end
      end
      ST_PDN: begin
        if (i_wake || urgent) begin
          nxt_cke   = 1'b1;
          nxt_busy  = 1'b0;
          nxt_state = ST_IDLE;
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  assign consume = (nxt_cmd == CMD_REF) && nxt_cke;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cmd_q  <= CMD_DESEL;
      cke_q  <= 1'b1;
      a10_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      state  <= nxt_state;
      cmd_q  <= nxt_cmd;
      cke_q  <= nxt_cke;
      a10_q  <= nxt_a10;
      busy_q <= nxt_busy;
    end
  end

  assign o_cke    = cke_q;
  assign o_cs_n   = cmd_q.cs_n;
  assign o_ras_n  = cmd_q.ras_n;
  assign o_cas_n  = cmd_q.cas_n;
  assign o_we_n   = cmd_q.we_n;
  assign o_a10    = a10_q;
  assign o_busy   = busy_q;
  assign o_urgent = urgent;

  // R6: self-refresh entry only when the banks were seen idle
  a_r6_sr_entry_idle: assert property (@(posedge clk) disable iff (rst)
    (!o_cs_n && !o_ras_n && !o_cas_n && o_we_n && !o_cke) |-> $past(i_banks_idle));

  // R7: self refresh keeps CKE low
  a_r7_sref_cke_low: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SREF) |-> !o_cke);

  // R8: exit window is silent with CKE high
  a_r8_xsr_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XSR) |-> (o_cs_n && o_cke && o_busy));

  // R8: CKE rises only with deselect on the command pins
  a_r8_cke_rise_deselect: assert property (@(posedge clk) disable iff (rst)
    $rose(o_cke) |-> o_cs_n);

  // R5: an auto refresh is always covered by busy
  a_r5_ref_busy: assert property (@(posedge clk) disable iff (rst)
    (!o_cs_n && !o_ras_n && !o_cas_n && o_we_n) |-> o_busy);

endmodule

// File: tb/dram_refresh_pm_bench.sv
module dram_refresh_pm_bench;

  localparam int REFI_W = 8;
  localparam int CMAX   = 3;
  localparam int TRFC   = 4;
  localparam int TRP    = 2;
  localparam int TXSR   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [REFI_W-1:0] refi = 8'd20;
  logic grant = 1'b0, idle = 1'b1, sleep = 1'b0, pd = 1'b0, wake = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, a10, busy, urgent;

  int n_chk = 0;
  int n_fail = 0;
  int n = 0;
  int wd = 0;

  always #10 clk = ~clk;

  dram_refresh_pm #(.REFI_W(REFI_W), .CRED_MAX(CMAX), .TRFC_CYC(TRFC),
                    .TRP_CYC(TRP), .TXSR_CYC(TXSR)) u_dram_refresh_pm (
    .clk(clk), .rst(rst), .i_refi_cycles(refi), .i_grant(grant),
    .i_banks_idle(idle), .i_sleep_req(sleep), .i_pd_req(pd), .i_wake(wake),
    .o_cke(cke), .o_cs_n(cs_n), .o_ras_n(ras_n), .o_cas_n(cas_n),
    .o_we_n(we_n), .o_a10(a10), .o_busy(busy), .o_urgent(urgent));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d expected < 150000", wd);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    n++;
  endtask

  function automatic bit is_ref();
    return !cs_n && !ras_n && !cas_n && we_n && cke;
  endfunction

  function automatic bit is_pre();
    return !cs_n && !ras_n && cas_n && !we_n;
  endfunction

  task automatic start(int r, bit g, bit bi, bit s, bit p);
    @(negedge clk);
    rst = 1'b1; refi = REFI_W'(r); grant = g; idle = bi;
    sleep = s; pd = p; wake = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    n = 0;
  endtask

  task automatic wait_ref(int limit, output int at);
    at = -1;
    while (n < limit) begin
      tick();
      if (is_ref()) begin
        at = n;
        return;
      end
    end
  endtask

  initial begin
    int refis[4];
    int at, prev, bad, base;
    refis = '{8, 13, 20, 31};

    // R1: reset state
    @(negedge clk);
    chk(cke && cs_n && !busy && !urgent, "R1 reset state",
        {cke, cs_n, busy, urgent}, 4'b1100);

    // R2 / R5: granted refresh cadence over several intervals
    for (int i = 0; i < 4; i++) begin
      int r;
      r = refis[i];
      start(r, 1'b1, 1'b1, 1'b0, 1'b0);
      wait_ref(4 * r, at);
      chk(at == r + 1, "R2 first granted refresh", at, r + 1);
      bad = 0;
      for (int j = 1; j < TRFC; j++) begin
        tick();
        if (!busy) bad++;
      end
      tick();
      chk(bad == 0 && !busy, "R5 busy window length", bad + 10 * busy, 0);
      prev = at;
      for (int k = 0; k < 3; k++) begin
        wait_ref(prev + 2 * r, at);
        chk(at - prev == r, "R2 refresh spacing", at - prev, r);
        prev = at;
      end
    end

    // R3: urgent refresh without grant
    start(20, 1'b0, 1'b1, 1'b0, 1'b0);
    bad = 0;
    while (n < 60) begin
      tick();
      if (!cs_n) bad++;
    end
    chk(bad == 0 && urgent, "R3 no command before ceiling, urgent set", bad, 0);
    tick();
    chk(is_ref(), "R3 urgent refresh issued", n, 61);
    prev = n;
    wait_ref(prev + 40, at);
    chk(at - prev == 20, "R3 urgent refresh spacing", at - prev, 20);

    // R4 / R12: urgent with open banks
    start(16, 1'b0, 1'b0, 1'b0, 1'b0);
    while (n < 49) tick();
    chk(is_pre() && a10, "R4 precharge-all on urgent", {cs_n, ras_n, cas_n, we_n, a10}, 5'b00101);
    tick();
    chk(busy && cs_n, "R12 busy during precharge wait", {busy, cs_n}, 2'b11);
    tick();
    chk(is_ref(), "R4 refresh TRP after precharge", n, 49 + TRP);

    // R6 / R7 / R8 / R9: self refresh round trip
    start(20, 1'b0, 1'b1, 1'b0, 1'b0);
    while (n < 45) tick();
    sleep = 1'b1;
    grant = 1'b1;
    tick();
    chk(!cs_n && !ras_n && !cas_n && we_n && !cke, "R6 self-refresh entry",
        {cke, cs_n, ras_n, cas_n, we_n}, 5'b00001);
    sleep = 1'b0;
    bad = 0;
    repeat (100) begin
      tick();
      if (cke || !cs_n || !busy) bad++;
    end
    chk(bad == 0, "R7 silent in self refresh (R12 busy)", bad, 0);
    wake = 1'b1;
    base = n;
    tick();
    wake = 1'b0;
    chk(cke && cs_n && busy, "R8 wake raises CKE with deselect",
        {cke, cs_n, busy}, 3'b111);
    bad = 0;
    for (int j = 2; j <= TXSR; j++) begin
      tick();
      if (!busy || !cs_n) bad++;
    end
    chk(bad == 0, "R8 exit window busy and quiet", bad, 0);
    tick();
    chk(!busy, "R8 busy drops after exit window", busy, 0);
    wait_ref(base + 60, at);
    chk(at == base + 20 + 2, "R9 credit cleared on exit", at - base, 22);

    // R10: power-down with an open bank, then wake
    start(20, 1'b1, 1'b0, 1'b0, 1'b1);
    tick();
    chk(!cke && cs_n && busy, "R10 power-down entry", {cke, cs_n, busy}, 3'b011);
    repeat (3) tick();
    pd = 1'b0;
    wake = 1'b1;
    tick();
    wake = 1'b0;
    chk(cke && cs_n && !busy, "R10 power-down exit", {cke, cs_n, busy}, 3'b110);

    // R11: power-down left by urgency
    start(20, 1'b1, 1'b0, 1'b0, 1'b1);
    bad = 0;
    while (n < 60) begin
      tick();
      if (cke) bad++;
    end
    chk(bad == 0, "R11 power-down held until ceiling", bad, 0);
    tick();
    chk(cke && cs_n, "R11 CKE raised on urgency", {cke, cs_n}, 2'b11);
    tick();
    chk(is_pre() && a10, "R11 precharge after auto exit", n, 62);
    repeat (TRP) tick();
    chk(is_ref(), "R11 refresh after auto exit", n, 62 + TRP);

    summary();
    $finish;
  end

endmodule